// File: doc/BRIEF.md
# CAN Error Confinement Counters

This block tracks the two fault tallies that a CAN node keeps, one for transmission faults and one for reception faults, and turns them into a 2-bit node state code. A protocol engine drives single-cycle event strobes into it. Error strobes raise a tally and success strobes lower it. Software sees the result through a read-only 16-bit status word and the state code, and takes no other part in the block.

Each tally is held as a 9-bit value, and only its low byte is shown. When a tally reaches 256 it overflows. From then on its byte shows a small residue and the tally no longer moves. A transmit overflow puts the node in bus off, and only an external recovery strobe brings it out. A receive overflow holds the node in error passive. An asynchronous active-low reset enters through a synchroniser, so that its release lines up with the clock.

Top module: `can_err_confine`

## Requirements
- R1: The status word carries the transmit tally's low 8 bits in bits 15..8 and the receive tally's low 8 bits in bits 7..0. The word is output only.
- R2: After reset both tallies are 0 and the state code is 2'b00.
- R3: A transmit error strobe adds 8 to the transmit tally. A transmit success strobe subtracts 1, and a tally of 0 stays at 0.
- R4: A receive error strobe adds 1 to the receive tally, or adds 8 when the severe flag is high in the same cycle. A receive success strobe subtracts 1, and a tally of 0 stays at 0. The severe flag on its own changes nothing.
- R5: When an error strobe and a success strobe reach the same tally in the same cycle, only the error strobe takes effect.
- R6: The state code is 2'b01 (warning) when either tally is 96 or more and both tallies are below 128. It is 2'b00 when both tallies are below 96.
- R7: The state code is 2'b10 (error passive) when either tally is 128 or more, or when the receive tally has overflowed, as long as the transmit tally has not overflowed.
- R8: A tally that reaches 256 or more has overflowed. Its shown byte is then its low 8 bits (0 to 7), and it ignores every later error and success strobe until it is cleared.
- R9: An overflowed transmit tally gives state code 2'b11 (bus off), which takes priority over every other code.
- R10: A recovery strobe during bus off clears both tallies and returns the state code to 2'b00 on the next cycle. A recovery strobe at any other time is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_err_i | input | 1 | Transmit error event strobe |
| tx_ok_i | input | 1 | Transmit success event strobe |
| rx_err_i | input | 1 | Receive error event strobe |
| rx_severe_i | input | 1 | Marks a receive error as severe (step of 8) |
| rx_ok_i | input | 1 | Receive success event strobe |
| recover_i | input | 1 | Bus-off recovery strobe |
| status_o | output | 16 | {transmit byte, receive byte} |
| node_state_o | output | 2 | 00 active, 01 warning, 10 passive, 11 bus off |

## Verification
The bench builds the block with its default parameters: 9-bit tallies, steps of 8 and 1, limits of 96 and 128, and a two-stage reset synchroniser. With these values the bench can reach every boundary in a few hundred cycles. Walking the receive tally one step at a time crosses 95/96, 127/128 and then overflow. Driving the transmit tally with an odd decrement lands its overflow on a non-zero residue (263 shown as 7) rather than on an aligned 256.

// File: rtl/can_ecc_pkg.sv
package can_ecc_pkg;
  typedef enum logic [1:0] {
    NS_ACTIVE  = 2'b00,
    NS_WARN    = 2'b01,
    NS_PASSIVE = 2'b10,
    NS_BUSOFF  = 2'b11
  } node_state_e;
endpackage

// File: rtl/ecc_rst_sync.sv
module ecc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/ecc_err_counter.sv
module ecc_err_counter #(
  parameter int CNT_W      = 9,
  parameter int SMALL_STEP = 1,
  parameter int BIG_STEP   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             inc_i,
  input  logic             big_i,
  input  logic             dec_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ovf_o
);
  localparam logic [CNT_W-1:0] STEP_S = CNT_W'(SMALL_STEP);
  localparam logic [CNT_W-1:0] STEP_B = CNT_W'(BIG_STEP);
  localparam logic [CNT_W-1:0] ONE    = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic             ovf;

  // overflow once the top bit is reached (2**(CNT_W-1))
  assign ovf = cnt_q[CNT_W-1];

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (clr_i) begin
      cnt_d  = '0;
      cnt_en = 1'b1;
    end else if (!ovf) begin
      if (inc_i) begin
        cnt_d  = cnt_q + (big_i ? STEP_B : STEP_S);
        cnt_en = 1'b1;
      end else if (dec_i && (cnt_q != '0)) begin
        cnt_d  = cnt_q - ONE;
        cnt_en = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
  assign ovf_o = ovf;

  AST_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !clr_i) |=> $stable(cnt_q)); // R8

  AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (cnt_q == '0)); // R10

  AST_INC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_i && !ovf && !clr_i) |=>
      (cnt_q == $past(cnt_q) + ($past(big_i) ? STEP_B : STEP_S))); // R5

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_i && !inc_i && !clr_i && (cnt_q == '0)) |=> (cnt_q == '0)); // R3
endmodule

// File: rtl/ecc_state_decode.sv
module ecc_state_decode
  import can_ecc_pkg::*;
#(
  parameter int CNT_W    = 9,
  parameter int WARN_LIM = 96,
  parameter int PASS_LIM = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] tx_cnt_i,
  input  logic [CNT_W-1:0] rx_cnt_i,
  input  logic             tx_ovf_i,
  input  logic             rx_ovf_i,
  output node_state_e      state_o
);
  localparam logic [CNT_W-1:0] WARN_V = CNT_W'(WARN_LIM);
  localparam logic [CNT_W-1:0] PASS_V = CNT_W'(PASS_LIM);

  logic any_warn, any_pass;

  assign any_warn = (tx_cnt_i >= WARN_V) || (rx_cnt_i >= WARN_V);
  assign any_pass = (tx_cnt_i >= PASS_V) || (rx_cnt_i >= PASS_V) || rx_ovf_i;

  always_comb begin
    if (tx_ovf_i)      state_o = NS_BUSOFF;
    else if (any_pass) state_o = NS_PASSIVE;
    else if (any_warn) state_o = NS_WARN;
    else               state_o = NS_ACTIVE;
  end

  AST_BUSOFF_PRIO: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ovf_i |-> (state_o == NS_BUSOFF)); // R9

  AST_RX_OVF_PASSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_ovf_i && !tx_ovf_i) |-> (state_o == NS_PASSIVE)); // R7
endmodule

// File: rtl/can_err_confine.sv
module can_err_confine
  import can_ecc_pkg::*;
#(
  parameter int CNT_W          = 9,
  parameter int SHOW_W         = 8,
  parameter int TX_ERR_STEP    = 8,
  parameter int RX_ERR_STEP    = 1,
  parameter int RX_SEVERE_STEP = 8,
  parameter int WARN_LIM       = 96,
  parameter int PASS_LIM       = 128,
  parameter int SYNC_STAGES    = 2,
  localparam int STAT_W        = 2 * SHOW_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_err_i,
  input  logic              tx_ok_i,
  input  logic              rx_err_i,
  input  logic              rx_severe_i,
  input  logic              rx_ok_i,
  input  logic              recover_i,
  output logic [STAT_W-1:0] status_o,
  output logic [1:0]        node_state_o
);
  logic             rst_core_n;
  logic [CNT_W-1:0] tx_cnt, rx_cnt;
  logic             tx_ovf, rx_ovf;
  logic             recover_ok;
  node_state_e      state;

  ecc_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  // recovery acts only while the transmit tally is in overflow
  assign recover_ok = recover_i && tx_ovf;

  ecc_err_counter #(
    .CNT_W(CNT_W), .SMALL_STEP(TX_ERR_STEP), .BIG_STEP(TX_ERR_STEP)
  ) u_tx (
    .clk   (clk),
    .rst_n (rst_core_n),
    .clr_i (recover_ok),
    .inc_i (tx_err_i),
    .big_i (1'b0),
    .dec_i (tx_ok_i),
    .cnt_o (tx_cnt),
    .ovf_o (tx_ovf)
  );

  ecc_err_counter #(
    .CNT_W(CNT_W), .SMALL_STEP(RX_ERR_STEP), .BIG_STEP(RX_SEVERE_STEP)
  ) u_rx (
    .clk   (clk),
    .rst_n (rst_core_n),
    .clr_i (recover_ok),
    .inc_i (rx_err_i),
    .big_i (rx_severe_i),
    .dec_i (rx_ok_i),
    .cnt_o (rx_cnt),
    .ovf_o (rx_ovf)
  );

  ecc_state_decode #(
    .CNT_W(CNT_W), .WARN_LIM(WARN_LIM), .PASS_LIM(PASS_LIM)
  ) u_dec (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .tx_cnt_i (tx_cnt),
    .rx_cnt_i (rx_cnt),
    .tx_ovf_i (tx_ovf),
    .rx_ovf_i (rx_ovf),
    .state_o  (state)
  );

  assign status_o     = {tx_cnt[SHOW_W-1:0], rx_cnt[SHOW_W-1:0]};
  assign node_state_o = state;

  AST_RECOVER_CLEAR: assert property (@(posedge clk) disable iff (!rst_core_n)
    (recover_i && node_state_o == NS_BUSOFF) |=>
      (status_o == '0 && node_state_o == NS_ACTIVE)); // R10

  AST_RECOVER_IGNORED: assert property (@(posedge clk) disable iff (!rst_core_n)
    (recover_i && node_state_o != NS_BUSOFF && !tx_err_i && !tx_ok_i &&
     !rx_err_i && !rx_ok_i) |=> $stable(status_o)); // R10
endmodule

// File: tb/sim_can_err_confine.sv
`timescale 1ns/1ps
module sim_can_err_confine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  stim = '0;
  logic [15:0] status;
  logic [1:0]  nstate;
  int          checks = 0;
  int          errors = 0;

  // stimulus bits: {tx_err, tx_ok, rx_err, rx_severe, rx_ok, recover}
  localparam logic [5:0] TXE = 6'b100000;
  localparam logic [5:0] TXO = 6'b010000;
  localparam logic [5:0] RXE = 6'b001000;
  localparam logic [5:0] RXS = 6'b000100;
  localparam logic [5:0] RXO = 6'b000010;
  localparam logic [5:0] REC = 6'b000001;

  always #4 clk = ~clk;

  can_err_confine u0 (
    .clk(clk), .rst_n(rst_n),
    .tx_err_i(stim[5]), .tx_ok_i(stim[4]), .rx_err_i(stim[3]),
    .rx_severe_i(stim[2]), .rx_ok_i(stim[1]), .recover_i(stim[0]),
    .status_o(status), .node_state_o(nstate)
  );

  // vector: {stimulus[23:18], status[17:2], state[1:0]}, walked from reset
  localparam int NV = 10;
  localparam logic [23:0] VEC [NV] = '{
    {6'b100000, 16'h0800, 2'b00},  // R3 tx error +8
    {6'b001000, 16'h0801, 2'b00},  // R4 rx error +1
    {6'b001100, 16'h0809, 2'b00},  // R4 severe rx error +8
    {6'b010000, 16'h0709, 2'b00},  // R3 tx success -1
    {6'b000010, 16'h0708, 2'b00},  // R4 rx success -1
    {6'b110000, 16'h0F08, 2'b00},  // R5 tx inc wins
    {6'b001010, 16'h0F09, 2'b00},  // R5 rx inc wins
    {6'b010010, 16'h0E08, 2'b00},  // R1 both decrement
    {6'b000100, 16'h0E08, 2'b00},  // R4 severe alone ignored
    {6'b000001, 16'h0E08, 2'b00}   // R10 recover ignored
  };

  task automatic chk(input string req, input logic [15:0] es, input logic [1:0] en);
    checks++;
    if (status !== es || nstate !== en) begin
      errors++;
      $display("FAIL %s: status=%h state=%b expected status=%h state=%b",
               req, status, nstate, es, en);
    end
  endtask

  task automatic step(input logic [5:0] s);
    stim = s;
    @(negedge clk);
    stim = '0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    stim  = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();
    chk("R2 reset state", 16'h0000, 2'b00);

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][23:18]);
      chk($sformatf("R1 R3 R4 R5 R10 vector %0d", i), VEC[i][17:2], VEC[i][1:0]);
    end

    // floor at zero
    do_reset();
    step(TXO | RXO);
    chk("R3 R4 no underflow", 16'h0000, 2'b00);

    // transmit thresholds and overflow residue
    for (int i = 1; i <= 31; i++) begin
      step(TXE);
      if (i == 11) chk("R6 tx 88 active", 16'h5800, 2'b00);
      if (i == 12) chk("R6 tx 96 warning", 16'h6000, 2'b01);
      if (i == 15) chk("R6 tx 120 warning", 16'h7800, 2'b01);
      if (i == 16) chk("R7 tx 128 passive", 16'h8000, 2'b10);
    end
    chk("R7 tx 248", 16'hF800, 2'b10);
    step(TXO);
    step(TXE);
    chk("R1 tx 255", 16'hFF00, 2'b10);
    step(TXE);
    chk("R8 R9 tx 263 bus off residue", 16'h0700, 2'b11);
    step(TXE);
    chk("R8 tx frozen vs error", 16'h0700, 2'b11);
    step(TXO);
    chk("R8 tx frozen vs success", 16'h0700, 2'b11);
    step(RXE);
    chk("R9 bus off priority with rx", 16'h0701, 2'b11);
    step(REC);
    chk("R10 recovery clears", 16'h0000, 2'b00);
    step(TXE);
    chk("R10 counting resumes", 16'h0800, 2'b00);

    // receive thresholds and overflow
    do_reset();
    for (int i = 1; i <= 255; i++) begin
      step(RXE);
      if (i == 95)  chk("R6 rx 95 active", 16'h005F, 2'b00);
      if (i == 96)  chk("R6 rx 96 warning", 16'h0060, 2'b01);
      if (i == 127) chk("R6 rx 127 warning", 16'h007F, 2'b01);
      if (i == 128) chk("R7 rx 128 passive", 16'h0080, 2'b10);
    end
    chk("R7 rx 255", 16'h00FF, 2'b10);
    step(RXE | RXS);
    chk("R8 rx 263 residue passive", 16'h0007, 2'b10);
    step(RXE);
    chk("R8 rx frozen vs error", 16'h0007, 2'b10);
    step(RXO);
    chk("R8 rx frozen vs success", 16'h0007, 2'b10);
    step(REC);
    chk("R10 recover ignored when passive", 16'h0007, 2'b10);
    step(TXE);
    chk("R7 rx overflow holds passive", 16'h0807, 2'b10);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule